// File: doc/BRIEF.md
# Protected Memory Region Access Checker

This block guards one address window of a memory controller. Software programs a window start and length, a whitelist of up to 160 requesting clients held in five 32-bit words, and a policy word. Every memory request presented on the request port is classified, and a registered allow or deny verdict comes back one clock later. Inside the window, a request passes only when its client is whitelisted, its access level is permitted for its direction, and its aperture tag satisfies the aperture rule. A secure-world bypass bit for each direction overrides all three conditions. Requests outside the window always pass.

The programming port is a plain write port with an index and a secure-world qualifier. The policy word can freeze all region registers until reset. It offers two freeze flavours: a full freeze, or a freeze that secure-world writes may still pass. A write refused by the freeze changes nothing and produces a one-cycle error pulse. Any denial latches a sticky violation flag that only reset clears.

Top module: `carveout_guard`

## Requirements
- R1: A request is in the window when base <= addr < base + size, with the sum taken one bit wider than the address so that it cannot wrap. Requests outside the window are allowed. After reset, base and size are 0, so nothing is in the window.
- R2: Register index 0 is the base, index 1 is the size, and indices 2 to 6 are whitelist words 0 to 4. Client c uses bit c%32 of word c/32. A 0 bit denies the client inside the window. Client IDs of 160 and above, and positions set in RESERVED_MASK, never grant access.
- R3: In the policy word (index 7), bits 6:3 are the read level mask and bits 10:7 are the write level mask. Mask bit n admits level n in that direction.
- R4: Policy bits 17:14 (read) and 21:18 (write) waive the level check for level n. A waived level passes whatever the mask holds.
- R5: Policy bits 13:11 hold an aperture tag. The aperture rule passes on an equal tag. It also passes on any tag when bit 25 is 1 and bit 26 is 0. Bit 26 set forces the equality test.
- R6: With policy bit 2 set, only untranslated requests can fall in the window, so a translated request is allowed.
- R7: A secure-world write is allowed in the window when policy bit 23 is 1. A secure-world read is allowed in the window when policy bit 24 is 1.
- R8: resp_valid_o and resp_allow_o show the verdict for a request sampled on the previous clock edge.
- R9: A denied request sets violation_o in the same cycle that its verdict appears. violation_o then stays set until reset.
- R10: With policy bit 1 set, every register write is refused. The one exception is when policy bit 0 is 1 and reg_secure_i is 1; that write is accepted.
- R11: A refused write leaves every register unchanged. wr_err_o pulses high for exactly one cycle, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | REG_AW | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_secure_i | input | 1 | Write comes from the secure world |
| req_valid_i | input | 1 | Request present |
| req_client_i | input | CLIENT_W | Requesting client ID |
| req_addr_i | input | ADDR_W | Request address |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_level_i | input | 2 | Access level 0 to 3 |
| req_secure_i | input | 1 | Request from the secure world |
| req_apid_i | input | 3 | Aperture tag of the request |
| req_translated_i | input | 1 | Address was translated |
| resp_valid_o | output | 1 | Verdict present |
| resp_allow_o | output | 1 | Verdict: 1 allow, 0 deny |
| violation_o | output | 1 | Sticky denial flag |
| wr_err_o | output | 1 | Refused-write pulse |

## Verification
The bench builds the block with ADDR_W=16, CLIENT_W=8 and the default five whitelist words. A reserved mask covers bits 7 to 13 of word 0 and bits 10 to 31 of word 4. With 16-bit addresses, a window placed near the top of the address space puts the non-wrapping end comparison within reach, and random addresses around a random window hit both edges often. The 8-bit client field reaches IDs above 159, and the reserved mask lets client 8 exercise a whitelist bit that is set but has no effect.

// File: rtl/carveout_pkg.sv
package carveout_pkg;
  localparam int LVL_N  = 4;
  localparam int APID_W = 3;

  localparam int CFG_PROT    = 0;
  localparam int CFG_LOCK    = 1;
  localparam int CFG_UNTR    = 2;
  localparam int CFG_RDM     = 3;
  localparam int CFG_WRM     = 7;
  localparam int CFG_APID    = 11;
  localparam int CFG_RDDIS   = 14;
  localparam int CFG_WRDIS   = 18;
  localparam int CFG_WRBYP   = 23;
  localparam int CFG_RDBYP   = 24;
  localparam int CFG_APALLOW = 25;
  localparam int CFG_APFORCE = 26;

  typedef struct packed {
    logic               untr_only;
    logic [LVL_N-1:0]   rd_mask;
    logic [LVL_N-1:0]   wr_mask;
    logic [APID_W-1:0]  apid;
    logic [LVL_N-1:0]   rd_dis;
    logic [LVL_N-1:0]   wr_dis;
    logic               wr_byp;
    logic               rd_byp;
    logic               ap_allow;
    logic               ap_force;
  } policy_t;

  function automatic policy_t policy_decode(input logic [31:0] w);
    policy_t p;
    p.untr_only = w[CFG_UNTR];
    p.rd_mask   = w[CFG_RDM +: LVL_N];
    p.wr_mask   = w[CFG_WRM +: LVL_N];
    p.apid      = w[CFG_APID +: APID_W];
    p.rd_dis    = w[CFG_RDDIS +: LVL_N];
    p.wr_dis    = w[CFG_WRDIS +: LVL_N];
    p.wr_byp    = w[CFG_WRBYP];
    p.rd_byp    = w[CFG_RDBYP];
    p.ap_allow  = w[CFG_APALLOW];
    p.ap_force  = w[CFG_APFORCE];
    return p;
  endfunction
endpackage

// File: rtl/carveout_regs.sv
module carveout_regs import carveout_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int WL_WORDS = 5,
  parameter int REG_AW   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [REG_AW-1:0]      idx_i,
  input  logic [31:0]            wdata_i,
  input  logic                   secure_i,
  output logic [ADDR_W-1:0]      base_o,
  output logic [ADDR_W-1:0]      size_o,
  output logic [WL_WORDS*32-1:0] wl_o,
  output logic [31:0]            cfg_o,
  output logic                   wr_err_o
);
  localparam int IDX_BASE = 0;
  localparam int IDX_SIZE = 1;
  localparam int IDX_WL0  = 2;
  localparam int IDX_CFG  = IDX_WL0 + WL_WORDS;

  logic [ADDR_W-1:0] base_q, size_q;
  logic [31:0]       cfg_q;
  logic              wr_err_q;
  logic              locked, wr_ok, commit;

  // secure writes pass the freeze only in the softer protect flavour
  assign locked = cfg_q[CFG_LOCK];
  assign wr_ok  = ~locked | (cfg_q[CFG_PROT] & secure_i);
  assign commit = we_i & wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      size_q   <= '0;
      cfg_q    <= '0;
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= we_i & ~wr_ok;
      if (commit && idx_i == REG_AW'(IDX_BASE)) base_q <= wdata_i[ADDR_W-1:0];
      if (commit && idx_i == REG_AW'(IDX_SIZE)) size_q <= wdata_i[ADDR_W-1:0];
      if (commit && idx_i == REG_AW'(IDX_CFG))  cfg_q  <= wdata_i;
    end
  end

  for (genvar g = 0; g < WL_WORDS; g++) begin : g_wl
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '0;
      else if (commit && idx_i == REG_AW'(IDX_WL0 + g)) word_q <= wdata_i;
    end
    assign wl_o[g*32 +: 32] = word_q;
  end

  assign base_o   = base_q;
  assign size_o   = size_q;
  assign cfg_o    = cfg_q;
  assign wr_err_o = wr_err_q;

  // R10
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cfg_q[CFG_LOCK] && !cfg_q[CFG_PROT]) |=>
      ($stable(cfg_q) && $stable(base_q) && $stable(size_q) && $stable(wl_o)));

  // R11
  wr_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(we_i));
endmodule

// File: rtl/carveout_range.sv
module carveout_range #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              hit_o
);
  logic [ADDR_W:0] end_x;
  // one extra bit keeps a window ending past the top from wrapping
  assign end_x = {1'b0, base_i} + {1'b0, size_i};
  assign hit_o = (addr_i >= base_i) && ({1'b0, addr_i} < end_x);
endmodule

// File: rtl/carveout_policy.sv
module carveout_policy import carveout_pkg::*; #(
  parameter int                   CLIENT_W    = 8,
  parameter int                   WL_WORDS    = 5,
  parameter logic [WL_WORDS*32-1:0] RSVD_MASK = '0
) (
  input  logic                   hit_i,
  input  logic [31:0]            cfg_i,
  input  logic [WL_WORDS*32-1:0] wl_i,
  input  logic [CLIENT_W-1:0]    client_i,
  input  logic                   write_i,
  input  logic [1:0]             level_i,
  input  logic                   secure_i,
  input  logic [APID_W-1:0]      apid_i,
  input  logic                   translated_i,
  output logic                   allow_o
);
  localparam int WL_BITS = WL_WORDS * 32;
  localparam int ID_SPAN = 1 << CLIENT_W;

  policy_t          pol;
  logic [WL_BITS-1:0] grant_vec;
  logic [ID_SPAN-1:0] grant_full;
  logic in_scope, grant, lvl_ok, ap_ok, byp;

  assign pol       = policy_decode(cfg_i);
  assign grant_vec = wl_i & ~RSVD_MASK;

  for (genvar i = 0; i < ID_SPAN; i++) begin : g_id
    if (i < WL_BITS) begin : g_map
      assign grant_full[i] = grant_vec[i];
    end else begin : g_none
      assign grant_full[i] = 1'b0;
    end
  end

  assign grant    = grant_full[client_i];
  assign in_scope = hit_i & ~(pol.untr_only & translated_i);
  assign lvl_ok   = write_i ? (pol.wr_dis[level_i] | pol.wr_mask[level_i])
                            : (pol.rd_dis[level_i] | pol.rd_mask[level_i]);
  assign ap_ok    = (apid_i == pol.apid) | (pol.ap_allow & ~pol.ap_force);
  assign byp      = secure_i & (write_i ? pol.wr_byp : pol.rd_byp);
  assign allow_o  = ~in_scope | byp | (grant & lvl_ok & ap_ok);
endmodule

// File: rtl/carveout_guard.sv
module carveout_guard import carveout_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int CLIENT_W = 8,
  parameter int WL_WORDS = 5,
  parameter logic [WL_WORDS*32-1:0] RESERVED_MASK =
    {32'hFFFF_FC00, {((WL_WORDS-2)*32){1'b0}}, 32'h0000_3F80},
  localparam int REG_AW = $clog2(WL_WORDS + 3)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_idx_i,
  input  logic [31:0]         reg_wdata_i,
  input  logic                reg_secure_i,
  input  logic                req_valid_i,
  input  logic [CLIENT_W-1:0] req_client_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_write_i,
  input  logic [1:0]          req_level_i,
  input  logic                req_secure_i,
  input  logic [2:0]          req_apid_i,
  input  logic                req_translated_i,
  output logic                resp_valid_o,
  output logic                resp_allow_o,
  output logic                violation_o,
  output logic                wr_err_o
);
  logic [ADDR_W-1:0]      base, size;
  logic [WL_WORDS*32-1:0] wl;
  logic [31:0]            cfg;
  logic                   hit, allow;
  logic                   valid_q, allow_q, viol_q;

  carveout_regs #(.ADDR_W(ADDR_W), .WL_WORDS(WL_WORDS), .REG_AW(REG_AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .idx_i    (reg_idx_i),
    .wdata_i  (reg_wdata_i),
    .secure_i (reg_secure_i),
    .base_o   (base),
    .size_o   (size),
    .wl_o     (wl),
    .cfg_o    (cfg),
    .wr_err_o (wr_err_o)
  );

  carveout_range #(.ADDR_W(ADDR_W)) u_range (
    .addr_i (req_addr_i),
    .base_i (base),
    .size_i (size),
    .hit_o  (hit)
  );

  carveout_policy #(.CLIENT_W(CLIENT_W), .WL_WORDS(WL_WORDS), .RSVD_MASK(RESERVED_MASK)) u_policy (
    .hit_i        (hit),
    .cfg_i        (cfg),
    .wl_i         (wl),
    .client_i     (req_client_i),
    .write_i      (req_write_i),
    .level_i      (req_level_i),
    .secure_i     (req_secure_i),
    .apid_i       (req_apid_i),
    .translated_i (req_translated_i),
    .allow_o      (allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) allow_q <= allow;
      viol_q  <= viol_q | (req_valid_i & ~allow);
    end
  end

  assign resp_valid_o = valid_q;
  assign resp_allow_o = allow_q;
  assign violation_o  = viol_q;

  // R8
  resp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  // R1
  outside_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> resp_allow_o);

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> violation_o);

  // R9
  deny_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_allow_o) |-> violation_o);
endmodule

// File: tb/carveout_guard_bench.sv
module carveout_guard_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int WW = 5;
  localparam logic [WW*32-1:0] RSVD = {32'hFFFF_FC00, 96'h0, 32'h0000_3F80};

  localparam logic [31:0] C_PROT    = 32'h1;
  localparam logic [31:0] C_LOCK    = 32'h2;
  localparam logic [31:0] C_UNTR    = 32'h4;
  localparam logic [31:0] C_RD0     = 32'h8;
  localparam logic [31:0] C_WR0     = 32'h80;
  localparam logic [31:0] C_RDDIS2  = 32'h1 << 16;
  localparam logic [31:0] C_WRBYP   = 32'h1 << 23;
  localparam logic [31:0] C_APALLOW = 32'h1 << 25;
  localparam logic [31:0] C_APFORCE = 32'h1 << 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic          reg_we = 1'b0, reg_sec = 1'b0;
  logic [2:0]    reg_idx = '0;
  logic [31:0]   reg_wdata = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_sec = 1'b0, req_tr = 1'b0;
  logic [CW-1:0] req_client = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_level = '0;
  logic [2:0]    req_apid = '0;
  logic          resp_valid, resp_allow, violation, wr_err;

  carveout_guard #(.ADDR_W(AW), .CLIENT_W(CW), .WL_WORDS(WW), .RESERVED_MASK(RSVD)) u_carveout_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_secure_i(reg_sec),
    .req_valid_i(req_valid), .req_client_i(req_client), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_level_i(req_level), .req_secure_i(req_sec),
    .req_apid_i(req_apid), .req_translated_i(req_tr),
    .resp_valid_o(resp_valid), .resp_allow_o(resp_allow),
    .violation_o(violation), .wr_err_o(wr_err)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base, m_size;
  logic [31:0]   m_wl [WW];
  logic [31:0]   m_cfg;
  logic          m_viol;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic m_allow(input logic [CW-1:0] c, input logic [AW-1:0] a, input logic w,
                                   input logic [1:0] l, input logic s, input logic [2:0] ap, input logic tr);
    logic [AW:0] endp;
    logic hit, inr, g, lv, apok, byp;
    int idx;
    endp = {1'b0, m_base} + {1'b0, m_size};
    hit  = (a >= m_base) && ({1'b0, a} < endp);
    inr  = hit && !(m_cfg[2] && tr);
    idx  = int'(c);
    g    = 1'b0;
    if (idx < WW*32) g = m_wl[idx/32][idx%32] && !RSVD[idx];
    lv   = w ? (m_cfg[18+int'(l)] || m_cfg[7+int'(l)]) : (m_cfg[14+int'(l)] || m_cfg[3+int'(l)]);
    apok = (ap == m_cfg[13:11]) || (m_cfg[25] && !m_cfg[26]);
    byp  = s && (w ? m_cfg[23] : m_cfg[24]);
    return !inr || byp || (g && lv && apok);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_we = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    m_base = '0; m_size = '0; m_cfg = '0; m_viol = 1'b0;
    for (int i = 0; i < WW; i++) m_wl[i] = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset resp_valid", resp_valid, 0);
    chk("R9", "reset violation", violation, 0);
    chk("R11", "reset wr_err", wr_err, 0);
  endtask

  task automatic do_write(input int idx, input logic [31:0] data, input logic sec);
    logic err;
    err = m_cfg[1] && !(m_cfg[0] && sec);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = data; reg_sec = sec;
    @(negedge clk);
    reg_we = 1'b0;
    chk(err ? "R10" : "R11", "wr_err", wr_err, err);
    if (!err) begin
      case (idx)
        0: m_base = data[AW-1:0];
        1: m_size = data[AW-1:0];
        7: m_cfg  = data;
        default: m_wl[idx-2] = data;
      endcase
    end
  endtask

  // exp < 0 takes the bench model; otherwise the hand-worked value
  task automatic do_req(input int c, input logic [AW-1:0] a, input logic w, input int l,
                        input logic s, input int ap, input logic tr, input int exp, input string rq);
    logic e;
    e = (exp < 0) ? m_allow(CW'(c), a, w, 2'(l), s, 3'(ap), tr) : exp[0];
    if (!e) m_viol = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_client = CW'(c); req_addr = a; req_write = w;
    req_level = 2'(l); req_sec = s; req_apid = 3'(ap); req_tr = tr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "allow", resp_allow, e);
    chk("R8", "resp_valid", resp_valid, 1);
    chk("R9", "violation", violation, m_viol);
  endtask

  initial begin
    #1ms;
    errors++; checks++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] cfg;
    void'($urandom(32'd4242));
    do_reset();
    do_req(4, 16'h0000, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R1");

    do_write(0, 32'h1000, 1'b0);
    do_write(1, 32'h0800, 1'b0);
    do_write(2, 32'h0000_0108, 1'b0);
    cfg = C_RD0 | C_WR0;
    do_write(7, cfg, 1'b0);

    do_req(3, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R2");
    do_req(3, 16'h17FF, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R1");
    do_req(4, 16'h1800, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R1");
    do_req(4, 16'h0FFF, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R1");
    do_req(4, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R2");
    do_req(8, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R2");
    do_req(200, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R2");
    do_req(3, 16'h1000, 1'b0, 2, 1'b0, 0, 1'b0, 0, "R3");
    do_req(3, 16'h1000, 1'b1, 0, 1'b0, 0, 1'b0, 1, "R3");
    do_req(3, 16'h1000, 1'b1, 1, 1'b0, 0, 1'b0, 0, "R3");

    cfg |= C_RDDIS2;
    do_write(7, cfg, 1'b0);
    do_req(3, 16'h1000, 1'b0, 2, 1'b0, 0, 1'b0, 1, "R4");
    do_req(3, 16'h1000, 1'b1, 2, 1'b0, 0, 1'b0, 0, "R4");

    do_req(3, 16'h1000, 1'b0, 0, 1'b0, 5, 1'b0, 0, "R5");
    do_write(7, cfg | C_APALLOW, 1'b0);
    do_req(3, 16'h1000, 1'b0, 0, 1'b0, 5, 1'b0, 1, "R5");
    do_write(7, cfg | C_APALLOW | C_APFORCE, 1'b0);
    do_req(3, 16'h1000, 1'b0, 0, 1'b0, 5, 1'b0, 0, "R5");

    do_write(7, cfg | C_UNTR, 1'b0);
    do_req(4, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b1, 1, "R6");
    do_req(4, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R6");

    do_write(7, cfg | C_WRBYP, 1'b0);
    do_req(4, 16'h1000, 1'b1, 3, 1'b1, 6, 1'b0, 1, "R7");
    do_req(4, 16'h1000, 1'b0, 0, 1'b1, 0, 1'b0, 0, "R7");
    do_req(4, 16'h1000, 1'b1, 0, 1'b0, 0, 1'b0, 0, "R7");

    do_write(0, 32'hF000, 1'b0);
    do_write(1, 32'h2000, 1'b0);
    do_req(4, 16'hFFFF, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R1");
    do_req(4, 16'h0000, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R1");

    // full freeze
    do_reset();
    do_write(0, 32'h1000, 1'b0);
    do_write(1, 32'h0800, 1'b0);
    do_write(7, C_RD0 | C_WR0 | C_LOCK, 1'b0);
    do_write(0, 32'h2000, 1'b1);
    @(negedge clk);
    chk("R11", "wr_err second cycle", wr_err, 0);
    do_write(7, 32'h0, 1'b0);
    do_req(4, 16'h1000, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R11");
    do_req(4, 16'h2000, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R11");

    // freeze with secure pass
    do_reset();
    do_write(0, 32'h1000, 1'b0);
    do_write(1, 32'h0800, 1'b0);
    do_write(7, C_RD0 | C_WR0 | C_LOCK | C_PROT, 1'b0);
    do_write(1, 32'h0100, 1'b0);
    do_req(4, 16'h1400, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R10");
    do_write(1, 32'h0100, 1'b1);
    do_req(4, 16'h1400, 1'b0, 0, 1'b0, 0, 1'b0, 1, "R10");

    // random mix against the bench model
    do_reset();
    do_write(0, 32'h4000, 1'b0);
    do_write(1, 32'h0400, 1'b0);
    do_write(2, $urandom(), 1'b0);
    do_write(7, $urandom() & ~C_LOCK, 1'b0);
    for (int i = 0; i < 400; i++) begin
      int r, c;
      logic [AW-1:0] a;
      r = int'($urandom_range(0, 11));
      if (r == 0) do_write(7, $urandom() & ~C_LOCK, 1'($urandom_range(0, 1)));
      else if (r == 1) do_write(int'($urandom_range(2, 6)), $urandom(), 1'b0);
      else if (r == 2) do_write(int'($urandom_range(0, 1)), $urandom_range(0, 16'h1000) + 32'hE800, 1'b0);
      else begin
        c = (r < 8) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 255));
        a = AW'(int'(m_base) + int'($urandom_range(0, int'(m_size) + 32)) - 16);
        do_req(c, a, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
               1'($urandom_range(0, 1)), -1, "R2");
      end
    end
    finish_run();
  end
endmodule